// File: doc/BRIEF.md
# Word DMA Channel Engine

This block is one channel of a word-oriented DMA controller. It copies 32-bit words from a source address to a destination address over a simple request/grant memory port. In place of copying, it can also store a programmed fill constant into every destination word. Software configures the channel through a small register port. The registers are source and destination addresses, total word count, block size, a prescaled interval timer, fill data and a control word. The number of words moved so far can be read back.

Work is split into blocks of 2^n words. After each block the engine waits for the interval timer before it starts the next block. A channel runs once and then clears its busy flag. In repeating mode it instead restarts the count and restores whichever addresses are flagged for reload, so the channel keeps running until software stops it. An interrupt pulse marks the end of every pass through the total count.

Top module: `wdma_chan`

## Requirements
- R1: The source register is at index 0 and the destination register is at index 1. The two low bits of a written value are forced to zero, both on readback and on every memory address the engine drives.
- R2: In copy mode, each word is read from the working source address and then written to the working destination address. The read-only register at index 6 counts the words written. It is cleared when the channel starts.
- R3: Each address has an update mode: 0 adds 4 after every access, 1 subtracts 4, and 2 or 3 keep the address fixed. Control bits [14:13] set the source mode and control bits [11:10] set the destination mode.
- R4: When control bit 20 (fill) is set, every destination word receives the value of register 4 and no memory read is issued.
- R5: Control bits [19:16] hold n, and a block holds 2^n words. The last block is shortened to the remaining count, and exactly the number of words in register 2 (24 bits) is written.
- R6: Register 3 holds the interval in bits [15:0] and the prescaler p in bits [17:16]. Between two blocks the memory port is idle for exactly I*D+1 cycles, where I is the interval and D is 1, 4, 16 or 64 for p = 0..3.
- R7: Control bit 28 (immediate) set makes the first memory request appear in the cycle after the enable write. With bit 28 clear, the first block waits I*D+1 cycles first.
- R8: Control bit 31 is the busy flag and reads back 0 after reset. For a non-repeating transfer it clears once the last word is written. If control bit 30 is set, the output irq goes high for exactly one cycle at that point; if bit 30 is clear, irq stays low.
- R9: Control bit 29 (repeat) set means that when the count is reached, irq pulses and busy stays set. The count restarts, and an address whose reload flag is set returns to its programmed value (bit 15 for the source, bit 12 for the destination). An address without the flag keeps advancing.
- R10: Writing the control register with bit 31 clear stops the channel at once. No memory request is issued afterwards.
- R11: A memory request holds its address and direction stable until mem_gnt is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for cfg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access completes in a cycle with mem_req high |
| mem_rdata | input | 32 | Read data, valid with mem_gnt |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is the boundary of a repeat pass. There, the last word of a pass, the reload of one address, the continued advance of the other and the irq pulse all fall within the same couple of cycles. The bench runs a repeating channel with only the source reload flag set. It watches irq at the falling edge and stops the channel in the very cycle the second pulse is visible. This leaves a fixed four-word image in memory, which shows both the source reload and the continued destination advance. The interval formula is checked separately by timing the gaps between write grants for each prescaler setting.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
  localparam int ADDR_W = 32;
  localparam int CFG_W  = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR} wdma_state_e;

  typedef enum logic [1:0] {
    UPD_INC = 2'd0,
    UPD_DEC = 2'd1,
    UPD_FIX = 2'd2,
    UPD_RSV = 2'd3
  } upd_mode_e;

  // register indices
  localparam logic [2:0] RA_SRC   = 3'd0;
  localparam logic [2:0] RA_DST   = 3'd1;
  localparam logic [2:0] RA_TOTAL = 3'd2;
  localparam logic [2:0] RA_TIMER = 3'd3;
  localparam logic [2:0] RA_FILL  = 3'd4;
  localparam logic [2:0] RA_CTRL  = 3'd5;
  localparam logic [2:0] RA_XFER  = 3'd6;

  // control word fields
  localparam int CB_DMODE  = 10;
  localparam int CB_DRLD   = 12;
  localparam int CB_SMODE  = 13;
  localparam int CB_SRLD   = 15;
  localparam int CB_BSIZE  = 16;
  localparam int CB_FILL   = 20;
  localparam int CB_IMM    = 28;
  localparam int CB_REPEAT = 29;
  localparam int CB_IRQEN  = 30;
  localparam int CB_BUSY   = 31;
endpackage

// File: rtl/wdma_addr_unit.sv
module wdma_addr_unit
  import wdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              reload,
  input  logic              step,
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] work,
  output logic [ADDR_W-1:0] prog
);
  logic [ADDR_W-1:0] next_step;

  always_comb begin
    case (upd_mode_e'(mode))
      UPD_INC: next_step = work + ADDR_W'(4);
      UPD_DEC: next_step = work - ADDR_W'(4);
      default: next_step = work;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work <= '0;
      prog <= '0;
    end else if (load) begin
      work <= {load_val[ADDR_W-1:2], 2'b00};
      prog <= {load_val[ADDR_W-1:2], 2'b00};
    end else if (reload) begin
      work <= prog;
    end else if (step) begin
      work <= next_step;
    end
  end
endmodule

// File: rtl/wdma_ticker.sv
module wdma_ticker #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [TW-1:0] interval,
  input  logic [1:0]    presc,
  output logic          expired
);
  localparam int PW = 6;

  logic [PW:0]   div;
  logic [PW-1:0] div_m1;
  logic [PW-1:0] pre;
  logic [TW-1:0] ticks;

  assign div     = (PW+1)'(1) << {presc, 1'b0};
  assign div_m1  = PW'(div - (PW+1)'(1));
  assign expired = (ticks == interval);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre   <= '0;
      ticks <= '0;
    end else if (!expired) begin
      if (pre == div_m1) begin
        pre   <= '0;
        ticks <= ticks + TW'(1);
      end else begin
        pre <= pre + PW'(1);
      end
    end
  end
endmodule

// File: rtl/wdma_chan.sv
module wdma_chan
  import wdma_pkg::*;
#(
  parameter int DW   = 32,
  parameter int TOTW = 24,
  parameter int XCW  = 28,
  parameter int TW   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic [DW-1:0]     mem_rdata,
  output logic              irq
);
  localparam int TMW = TW + 2;

  wdma_state_e       state;
  logic [CFG_W-1:0]  ctrl_q;
  logic [TOTW-1:0]   total_q, words_left, blk_left;
  logic [TMW-1:0]    timer_q;
  logic [DW-1:0]     fill_q, data_q;
  logic [XCW-1:0]    xfer_cnt;
  logic              irq_q, tick_exp;

  logic              ctl_wr, do_abort, do_start, wr_done, rpt_wrap;
  logic [TOTW-1:0]   blk_first, blk_next;
  wdma_state_e       op_first, op_next;

  logic [1:0]              au_load, au_reload, au_step;
  logic [1:0][1:0]         au_mode;
  logic [1:0][ADDR_W-1:0]  au_work, au_prog;

  function automatic logic [TOTW-1:0] blk_min(input logic [3:0] n,
                                             input logic [TOTW-1:0] left);
    logic [TOTW-1:0] full;
    full = TOTW'(1) << n;
    return (left < full) ? left : full;
  endfunction

  assign ctl_wr    = cfg_we && (cfg_addr == RA_CTRL);
  assign do_abort  = ctl_wr && !cfg_wdata[CB_BUSY];
  assign do_start  = ctl_wr && cfg_wdata[CB_BUSY] && (state == ST_IDLE);
  assign wr_done   = (state == ST_WR) && mem_gnt && !do_abort;
  assign rpt_wrap  = wr_done && (words_left == TOTW'(1)) && ctrl_q[CB_REPEAT];
  assign blk_first = blk_min(cfg_wdata[CB_BSIZE +: 4], total_q);
  assign blk_next  = blk_min(ctrl_q[CB_BSIZE +: 4], words_left);
  assign op_first  = cfg_wdata[CB_FILL] ? ST_WR : ST_RD;
  assign op_next   = ctrl_q[CB_FILL] ? ST_WR : ST_RD;

  // address units: index 0 = source, 1 = destination
  assign au_load[0]   = cfg_we && (cfg_addr == RA_SRC);
  assign au_load[1]   = cfg_we && (cfg_addr == RA_DST);
  assign au_reload[0] = rpt_wrap && ctrl_q[CB_SRLD];
  assign au_reload[1] = rpt_wrap && ctrl_q[CB_DRLD];
  assign au_step[0]   = (state == ST_RD) && mem_gnt && !do_abort;
  assign au_step[1]   = wr_done;
  assign au_mode[0]   = ctrl_q[CB_SMODE +: 2];
  assign au_mode[1]   = ctrl_q[CB_DMODE +: 2];

  for (genvar g = 0; g < 2; g++) begin : g_addr
    wdma_addr_unit u_au (
      .clk      (clk),
      .rst      (rst),
      .load     (au_load[g]),
      .load_val (cfg_wdata[ADDR_W-1:0]),
      .reload   (au_reload[g]),
      .step     (au_step[g]),
      .mode     (au_mode[g]),
      .work     (au_work[g]),
      .prog     (au_prog[g])
    );
  end

  wdma_ticker #(.TW(TW)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .run      (state == ST_WAIT),
    .interval (timer_q[TW-1:0]),
    .presc    (timer_q[TW +: 2]),
    .expired  (tick_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ctrl_q     <= '0;
      total_q    <= '0;
      timer_q    <= '0;
      fill_q     <= '0;
      data_q     <= '0;
      words_left <= '0;
      blk_left   <= '0;
      xfer_cnt   <= '0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr)
          RA_TOTAL: total_q <= cfg_wdata[TOTW-1:0];
          RA_TIMER: timer_q <= cfg_wdata[TMW-1:0];
          RA_FILL:  fill_q  <= cfg_wdata[DW-1:0];
          RA_CTRL:  ctrl_q[CB_BUSY-1:0] <= cfg_wdata[CB_BUSY-1:0];
          default: ;
        endcase
      end
      if (do_abort) begin
        ctrl_q[CB_BUSY] <= 1'b0;
        state           <= ST_IDLE;
      end else if (do_start) begin
        if (total_q == '0) begin
          irq_q <= cfg_wdata[CB_IRQEN];
        end else begin
          ctrl_q[CB_BUSY] <= 1'b1;
          words_left      <= total_q;
          blk_left        <= blk_first;
          xfer_cnt        <= '0;
          state           <= cfg_wdata[CB_IMM] ? op_first : ST_WAIT;
        end
      end else begin
        case (state)
          ST_WAIT: if (tick_exp) begin
            blk_left <= blk_next;
            state    <= op_next;
          end
          ST_RD: if (mem_gnt) begin
            data_q <= mem_rdata;
            state  <= ST_WR;
          end
          ST_WR: if (mem_gnt) begin
            xfer_cnt   <= xfer_cnt + XCW'(1);
            words_left <= words_left - TOTW'(1);
            blk_left   <= blk_left - TOTW'(1);
            if (words_left == TOTW'(1)) begin
              irq_q <= ctrl_q[CB_IRQEN];
              if (ctrl_q[CB_REPEAT]) begin
                words_left <= total_q;
                state      <= ST_WAIT;
              end else begin
                ctrl_q[CB_BUSY] <= 1'b0;
                state           <= ST_IDLE;
              end
            end else if (blk_left == TOTW'(1)) begin
              state <= ST_WAIT;
            end else begin
              state <= op_next;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (cfg_addr)
        RA_SRC:   cfg_rdata <= CFG_W'(au_prog[0]);
        RA_DST:   cfg_rdata <= CFG_W'(au_prog[1]);
        RA_TOTAL: cfg_rdata <= CFG_W'(total_q);
        RA_TIMER: cfg_rdata <= CFG_W'(timer_q);
        RA_FILL:  cfg_rdata <= CFG_W'(fill_q);
        RA_CTRL:  cfg_rdata <= ctrl_q;
        RA_XFER:  cfg_rdata <= CFG_W'(xfer_cnt);
        default:  cfg_rdata <= '0;
      endcase
    end
  end

  assign mem_req   = (state == ST_RD) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign mem_addr  = (state == ST_RD) ? au_work[0] : au_work[1];
  assign mem_wdata = ctrl_q[CB_FILL] ? fill_q : data_q;
  assign irq       = irq_q;
endmodule

// File: rtl/wdma_chan_chk.sv
module wdma_chan_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        fill_on,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_gnt,
  input logic [31:0] mem_addr,
  input logic        irq
);
  // R10
  idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
  // R1
  addr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (!busy || (mem_req && $stable(mem_addr) && $stable(mem_we))));
  // R4
  fill_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && fill_on) |-> mem_we);
endmodule

bind wdma_chan wdma_chan_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (ctrl_q[31]),
  .fill_on  (ctrl_q[20]),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_gnt  (mem_gnt),
  .mem_addr (mem_addr),
  .irq      (irq)
);

// File: tb/sim_wdma_chan.sv
`timescale 1ns/1ps
module sim_wdma_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_req, mem_we, mem_gnt, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem   [256];
  logic [31:0] initm [256];
  logic [31:0] expm  [256];
  logic        stall = 1'b0;
  logic [1:0]  gcnt = 2'd0;
  int          checks = 0, errors = 0;
  int          cyc = 0, wr_n = 0, rd_n = 0, irq_n = 0;
  int          stamp [16];

  always #2 clk = ~clk;

  wdma_chan u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq)
  );

  // memory model
  assign mem_gnt   = stall ? (gcnt == 2'd0) : 1'b1;
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) begin
    gcnt <= (gcnt == 2'd2) ? 2'd0 : gcnt + 2'd1;
    if (mem_req && mem_gnt && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_gnt && mem_we) begin
      if (wr_n < 16) stamp[wr_n] <= cyc;
      wr_n <= wr_n + 1;
    end
    if (mem_req && mem_gnt && !mem_we) rd_n <= rd_n + 1;
    if (irq) irq_n <= irq_n + 1;
  end

  typedef struct packed {
    logic [9:0] src;
    logic [9:0] dst;
    logic [7:0] total;
    logic [3:0] bsz;
    logic [1:0] sm;
    logic [1:0] dm;
    logic       fill;
    logic       stl;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{10'h000, 10'h200, 8'd8, 4'd2,  2'd0, 2'd0, 1'b0, 1'b0},
    '{10'h07C, 10'h300, 8'd5, 4'd1,  2'd1, 2'd0, 1'b0, 1'b1},
    '{10'h040, 10'h280, 8'd4, 4'd0,  2'd2, 2'd1, 1'b0, 1'b0},
    '{10'h000, 10'h380, 8'd6, 4'd3,  2'd0, 2'd0, 1'b1, 1'b1},
    '{10'h010, 10'h3C0, 8'd3, 4'd15, 2'd3, 2'd2, 1'b0, 1'b0}
  };
  localparam logic [31:0] FILLV = 32'hF11A_5EED;

  function automatic logic [31:0] ctl(input logic go, irqen, rpt, imm, fill,
                                      input logic [3:0] bsz, input logic srl,
                                      input logic [1:0] sm, input logic drl,
                                      input logic [1:0] dm);
    return {go, irqen, rpt, imm, 7'b0, fill, bsz, srl, sm, drl, dm, 10'b0};
  endfunction

  function automatic logic [9:0] upd(input logic [9:0] a, input logic [1:0] m);
    if (m == 2'd0) return a + 10'd4;
    if (m == 2'd1) return a - 10'd4;
    return a;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(3'd5, v);
      if (!v[31]) return;
    end
  endtask

  task automatic mem_init();
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 32'h5A00_0000 | (i * 32'h0001_0003);
      initm[i] = 32'h5A00_0000 | (i * 32'h0001_0003);
      expm[i]  = 32'h5A00_0000 | (i * 32'h0001_0003);
    end
  endtask

  task automatic clr_mon();
    @(negedge clk);
    wr_n = 0; rd_n = 0; irq_n = 0;
  endtask

  task automatic interval_case(input int ival, input int p, input int gap);
    mem_init();
    wr(3'd1, 32'h200);
    wr(3'd2, 4);
    wr(3'd3, (p << 16) | ival);
    wr(3'd4, FILLV);
    clr_mon();
    wr(3'd5, ctl(1, 0, 0, 1, 1, 4'd1, 0, 2'd0, 0, 2'd0));
    wait_idle();
    // R6: gap between blocks, 1 within a block
    chk(stamp[1] - stamp[0] == 1, "R6 in-block gap", stamp[1] - stamp[0], 1);
    chk(stamp[2] - stamp[1] == gap, "R6 inter-block gap", stamp[2] - stamp[1], gap);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [9:0]  s, d;
    int          bad, n;
    mem_init();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state (R8)
    rd(3'd5, v);
    chk(v == 0 && !mem_req && !irq, "R8 reset state", v, 0);

    // R1 alignment
    wr(3'd0, 32'h0000_0123);
    rd(3'd0, v);
    chk(v == 32'h120, "R1 src low bits", v, 32'h120);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v);
    chk(v == 32'hFFFF_FFFC, "R1 dst low bits", v, 32'hFFFF_FFFC);

    // vector table: R2 R3 R4 R5 R11
    for (int t = 0; t < 5; t++) begin
      mem_init();
      stall = VECS[t].stl;
      s = VECS[t].src; d = VECS[t].dst;
      for (int k = 0; k < int'(VECS[t].total); k++) begin
        expm[d[9:2]] = VECS[t].fill ? FILLV : initm[s[9:2]];
        s = upd(s, VECS[t].sm);
        d = upd(d, VECS[t].dm);
      end
      wr(3'd0, 32'(VECS[t].src));
      wr(3'd1, 32'(VECS[t].dst));
      wr(3'd2, 32'(VECS[t].total));
      wr(3'd3, 0);
      wr(3'd4, FILLV);
      clr_mon();
      wr(3'd5, ctl(1, 1, 0, 1, VECS[t].fill, VECS[t].bsz, 0, VECS[t].sm, 0, VECS[t].dm));
      wait_idle();
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) bad++;
      chk(bad == 0, "R2 R3 R11 memory image", bad, 0);
      chk(wr_n == int'(VECS[t].total), "R5 write count", wr_n, VECS[t].total);
      chk(rd_n == (VECS[t].fill ? 0 : int'(VECS[t].total)), "R4 read count", rd_n,
          VECS[t].fill ? 0 : VECS[t].total);
      rd(3'd6, v);
      chk(v == 32'(VECS[t].total), "R2 transferred count", v, VECS[t].total);
      chk(irq_n == 1, "R8 irq pulses", irq_n, 1);
    end
    stall = 1'b0;

    // R6 interval and prescaler
    interval_case(0, 0, 2);
    interval_case(3, 1, 14);
    interval_case(2, 2, 34);
    interval_case(1, 3, 66);

    // R7 immediate versus delayed start
    wr(3'd2, 1);
    wr(3'd3, (1 << 16) | 2);
    wr(3'd5, ctl(1, 0, 0, 0, 1, 4'd0, 0, 2'd0, 0, 2'd0));
    n = 0;
    while (!mem_req && n < 500) begin @(negedge clk); n++; end
    chk(n == 9, "R7 delayed start", n, 9);
    wait_idle();
    wr(3'd5, ctl(1, 0, 0, 1, 1, 4'd0, 0, 2'd0, 0, 2'd0));
    chk(mem_req, "R7 immediate start", mem_req, 1);
    wait_idle();

    // R8 no irq when disabled
    clr_mon();
    wr(3'd2, 3);
    wr(3'd5, ctl(1, 0, 0, 1, 1, 4'd1, 0, 2'd0, 0, 2'd0));
    wait_idle();
    rd(3'd5, v);
    chk(irq_n == 0 && !v[31], "R8 irq disabled, busy clear", irq_n, 0);

    // R9 repeat with source reload only
    mem_init();
    wr(3'd0, 32'h000);
    wr(3'd1, 32'h200);
    wr(3'd2, 2);
    wr(3'd3, 0);
    clr_mon();
    wr(3'd5, ctl(1, 1, 1, 1, 0, 4'd1, 1, 2'd0, 0, 2'd0));
    n = 0;
    while (irq_n < 1 && n < 500) begin @(negedge clk); n++; end
    rd(3'd5, v);
    chk(v[31], "R9 busy held after pass", v[31], 1);
    n = 0;
    while (!irq && n < 500) begin @(negedge clk); n++; end
    cfg_we = 1'b1; cfg_addr = 3'd5;
    cfg_wdata = ctl(0, 1, 1, 1, 0, 4'd1, 1, 2'd0, 0, 2'd0);
    @(negedge clk);
    cfg_we = 1'b0;
    bad = 0;
    if (mem[8'h80] !== initm[0]) bad++;
    if (mem[8'h81] !== initm[1]) bad++;
    if (mem[8'h82] !== initm[0]) bad++;
    if (mem[8'h83] !== initm[1]) bad++;
    if (mem[8'h84] !== initm[8'h84]) bad++;
    chk(bad == 0, "R9 reload image", bad, 0);
    rd(3'd6, v);
    chk(v == 4, "R9 count after two passes", v, 4);

    // R10 abort in mid transfer
    stall = 1'b1;
    wr(3'd2, 20);
    clr_mon();
    wr(3'd5, ctl(1, 0, 0, 1, 0, 4'd4, 0, 2'd0, 0, 2'd0));
    n = 0;
    while (wr_n < 5 && n < 500) begin @(negedge clk); n++; end
    wr(3'd5, ctl(0, 0, 0, 1, 0, 4'd4, 0, 2'd0, 0, 2'd0));
    n = 0;
    for (int k = 0; k < 40; k++) begin
      if (mem_req) n++;
      @(negedge clk);
    end
    chk(n == 0, "R10 no request after stop", n, 0);
    rd(3'd5, v);
    chk(!v[31], "R10 busy clear after stop", v[31], 0);
    stall = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule